// File: doc/BRIEF.md
# Scatter-Gather Fragment Merge Engine

The block joins two independently fragmented buffer lists into one stream of copy commands. One input stream carries source descriptors and the other carries destination descriptors. Each is 128 bits wide and gives a start address, a byte count, a flag byte and user tags. The engine holds one live element from each side. It emits a segment as long as the shorter of the two remaining lengths, advances both addresses by that amount, and fetches a fresh element on whichever side has run out.

A flag on the source side marks the element that ends a packet. A flag on the destination side chooses what happens at that point: the engine either keeps filling the same destination element with the next packet, or drops what is left of it and starts the next packet in a new one. One cycle after the final segment of a packet is accepted, the engine presents a completion record for status generation. The record holds the tags of the packet-ending source element, the handle of the destination element that segment used, the interrupt request and the packet's total byte count. Moving the data, the bus protocols and fetching descriptors are left to neighbouring blocks.

Top module: `sg_merge_engine`

## Requirements
- R1: Descriptor fields are decoded as: address bits [63:0], byte count [87:64], flag byte [95:88], user handle [111:96]. Source descriptors also carry a user ID in [127:112].
- R2: A byte count of zero stands for 2^24 bytes on either side.
- R3: Each segment length is min(source remaining, destination remaining). After an accepted segment, both addresses advance by that length and both remaining counts drop by it.
- R4: src_ready (dst_ready) is high exactly when no element is held on that side. An element is held from its handshake until its bytes are used up or it is dropped. seg_valid is high exactly when both sides hold an element. After reset both readies are high.
- R5: seg_last is high when the segment uses up a source element whose flag bit 1 (end of packet) is set.
- R6: When a packet ends and the destination flag bit 1 is set, the rest of that destination element is dropped. When the bit is clear, the next packet continues in the same element at the advanced address.
- R7: cpl_valid pulses for exactly one cycle, in the cycle after a seg_last segment is accepted. It carries the user ID and handle of the packet-ending source element and the handle of the destination element used by that segment.
- R8: cpl_irq equals source flag bit 2 of the packet-ending element. Bit 2 on any other source element has no effect.
- R9: cpl_bytes equals the sum of the packet's segment lengths, modulo 2^PKT_CNT_W.
- R10: seg_src_attr and seg_dst_attr carry flag bits [7:4] of the current element on each side. seg_src_axi and seg_dst_axi carry flag bit 0.
- R11: While seg_valid is high and seg_ready is low, every segment output holds its value.
- R12: During and right after reset, seg_valid and cpl_valid are low and both readies are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_valid | input | 1 | Source descriptor offered |
| src_ready | output | 1 | Source slot empty, descriptor taken |
| src_desc | input | 128 | Source descriptor |
| dst_valid | input | 1 | Destination descriptor offered |
| dst_ready | output | 1 | Destination slot empty, descriptor taken |
| dst_desc | input | 128 | Destination descriptor |
| seg_valid | output | 1 | Segment command available |
| seg_ready | input | 1 | Segment command accepted |
| seg_src_addr | output | 64 | Segment read address |
| seg_dst_addr | output | 64 | Segment write address |
| seg_len | output | 25 | Segment length in bytes |
| seg_src_attr | output | 4 | Source cache/attribute code |
| seg_dst_attr | output | 4 | Destination cache/attribute code |
| seg_src_axi | output | 1 | Source fragment side select |
| seg_dst_axi | output | 1 | Destination fragment side select |
| seg_last | output | 1 | Segment ends the packet |
| cpl_valid | output | 1 | Completion record pulse |
| cpl_user_id | output | 16 | User ID of packet-ending source element |
| cpl_src_handle | output | 16 | Handle of packet-ending source element |
| cpl_dst_handle | output | 16 | Handle of destination element used last |
| cpl_irq | output | 1 | Interrupt request of the packet |
| cpl_bytes | output | PKT_CNT_W | Packet byte total |

## Verification
The bench targets several corner cases. In one, both sides run out in the same segment; a design that compared with the wrong inequality would keep one side alive and emit a zero-length segment, or stall. A zero count in a descriptor must become 2^24; a design that failed this would emit empty or tiny segments. Packets are packed into one destination element and also skipped across one, so a wrong drop decision shows up as a wrong write address on the next packet. An interrupt flag on a non-final source element must be ignored, and a design that latched it would raise cpl_irq. Back-pressure on the segment output is applied often, so a design that advanced on seg_valid instead of on the handshake would skip bytes.

// File: rtl/sgm_pkg.sv
// Shared constants, descriptor layout and the held-fragment type for the
// scatter-gather merge engine. The layout is fixed by the descriptor format.
package sgm_pkg;
    localparam int DESC_W      = 128;
    localparam int ADDR_W      = 64;
    localparam int CNT_W       = 24;
    localparam int LEN_W       = CNT_W + 1;
    localparam int FLAG_W      = 8;
    localparam int TAG_W       = 16;
    localparam int ATTR_W      = 4;
    localparam int ADDR_LSB    = 0;
    localparam int CNT_LSB     = ADDR_LSB + ADDR_W;
    localparam int FLAG_LSB    = CNT_LSB + CNT_W;
    localparam int HDL_LSB     = FLAG_LSB + FLAG_W;
    localparam int UID_LSB     = HDL_LSB + TAG_W;
    localparam int FLG_SIDE    = 0;
    localparam int FLG_MARK    = 1;   // end of packet (source) / skip (destination)
    localparam int FLG_IRQ     = 2;
    localparam int FLG_ATTR    = 4;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  rem;
        logic [FLAG_W-1:0] flags;
        logic [TAG_W-1:0]  handle;
        logic [TAG_W-1:0]  uid;
    } frag_t;

    // A zero count field stands for the largest length, 2^CNT_W.
    function automatic logic [LEN_W-1:0] decode_len(input logic [CNT_W-1:0] cnt);
        return (cnt == '0) ? (LEN_W'(1) << CNT_W) : {1'b0, cnt};
    endfunction
endpackage

// File: rtl/sgm_frag_slot.sv
// Holds one descriptor of one side and walks through it.
// Assumes: take only while held; finish asserted with take when the element is
// exhausted or must be abandoned. Accepts a new element only when empty.
module sgm_frag_slot
    import sgm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DESC_W-1:0] in_desc,
    input  logic              take,
    input  logic [LEN_W-1:0]  take_len,
    input  logic              finish,
    output logic              held,
    output frag_t             frag
);
    frag_t cur;
    logic  loaded;

    assign in_ready = !loaded;
    assign held     = loaded;
    assign frag     = cur;

    // Load a fresh element when empty, otherwise advance it by each accepted segment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loaded <= 1'b0;
            cur    <= '0;
        end else if (in_valid && !loaded) begin
            loaded     <= 1'b1;
            cur.addr   <= in_desc[ADDR_LSB +: ADDR_W];
            cur.rem    <= decode_len(in_desc[CNT_LSB +: CNT_W]);
            cur.flags  <= in_desc[FLAG_LSB +: FLAG_W];
            cur.handle <= in_desc[HDL_LSB +: TAG_W];
            cur.uid    <= in_desc[UID_LSB +: TAG_W];
        end else if (take && loaded) begin
            cur.addr <= cur.addr + ADDR_W'(take_len);
            cur.rem  <= cur.rem - take_len;
            if (finish) begin
                loaded <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sgm_seg_split.sv
// Combinational segment sizing: picks the shorter remaining length and decides
// which side is used up, whether the packet ends, and whether the destination
// element is abandoned. Assumes both remaining counts are non-zero when used.
module sgm_seg_split
    import sgm_pkg::*;
(
    input  logic [LEN_W-1:0] src_rem,
    input  logic [LEN_W-1:0] dst_rem,
    input  logic             src_eop,
    input  logic             dst_skip,
    output logic [LEN_W-1:0] len,
    output logic             src_done,
    output logic             dst_done,
    output logic             last
);
    logic src_shorter;
    logic dst_shorter;

    // Size the segment and mark the sides it finishes.
    always_comb begin
        src_shorter = (src_rem <= dst_rem);
        dst_shorter = (dst_rem <= src_rem);
        len         = src_shorter ? src_rem : dst_rem;
        src_done    = src_shorter;
        last        = src_shorter && src_eop;
        dst_done    = dst_shorter || (last && dst_skip);
    end
endmodule

// File: rtl/sgm_cpl_track.sv
// Sums the bytes of the current packet and registers the completion record in
// the cycle after the packet's final segment is accepted.
// Assumes fire is the segment handshake and last marks the packet end.
module sgm_cpl_track
    import sgm_pkg::*;
#(
    parameter int PKT_CNT_W = 27
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fire,
    input  logic                 last,
    input  logic [LEN_W-1:0]     len,
    input  logic [TAG_W-1:0]     src_uid,
    input  logic [TAG_W-1:0]     src_handle,
    input  logic [TAG_W-1:0]     dst_handle,
    input  logic                 irq,
    output logic                 cpl_valid,
    output logic [TAG_W-1:0]     cpl_user_id,
    output logic [TAG_W-1:0]     cpl_src_handle,
    output logic [TAG_W-1:0]     cpl_dst_handle,
    output logic                 cpl_irq,
    output logic [PKT_CNT_W-1:0] cpl_bytes
);
    logic [PKT_CNT_W-1:0] acc;
    logic [PKT_CNT_W-1:0] total;

    assign total = acc + PKT_CNT_W'(len);

    // Accumulate packet bytes, restarting after each packet end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (fire) begin
            acc <= last ? '0 : total;
        end
    end

    // Capture the completion record on the final segment; pulse valid once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpl_valid      <= 1'b0;
            cpl_user_id    <= '0;
            cpl_src_handle <= '0;
            cpl_dst_handle <= '0;
            cpl_irq        <= 1'b0;
            cpl_bytes      <= '0;
        end else begin
            cpl_valid <= fire && last;
            if (fire && last) begin
                cpl_user_id    <= src_uid;
                cpl_src_handle <= src_handle;
                cpl_dst_handle <= dst_handle;
                cpl_irq        <= irq;
                cpl_bytes      <= total;
            end
        end
    end
endmodule

// File: rtl/sg_merge_engine.sv
// Top of the scatter-gather merge engine. Holds one source and one destination
// element, issues segments of the shorter remaining length, and reports each
// finished packet. Assumes seg_ready follows valid/ready rules.
module sg_merge_engine
    import sgm_pkg::*;
#(
    parameter int PKT_CNT_W = 27
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 src_valid,
    output logic                 src_ready,
    input  logic [DESC_W-1:0]    src_desc,
    input  logic                 dst_valid,
    output logic                 dst_ready,
    input  logic [DESC_W-1:0]    dst_desc,
    output logic                 seg_valid,
    input  logic                 seg_ready,
    output logic [ADDR_W-1:0]    seg_src_addr,
    output logic [ADDR_W-1:0]    seg_dst_addr,
    output logic [LEN_W-1:0]     seg_len,
    output logic [ATTR_W-1:0]    seg_src_attr,
    output logic [ATTR_W-1:0]    seg_dst_attr,
    output logic                 seg_src_axi,
    output logic                 seg_dst_axi,
    output logic                 seg_last,
    output logic                 cpl_valid,
    output logic [TAG_W-1:0]     cpl_user_id,
    output logic [TAG_W-1:0]     cpl_src_handle,
    output logic [TAG_W-1:0]     cpl_dst_handle,
    output logic                 cpl_irq,
    output logic [PKT_CNT_W-1:0] cpl_bytes
);
    frag_t            s_frag;
    frag_t            d_frag;
    logic             s_held;
    logic             d_held;
    logic             fire;
    logic             s_done;
    logic             d_done;
    logic [LEN_W-1:0] len;
    logic             last;
    logic             unused_bits;

    assign seg_valid = s_held && d_held;
    assign fire      = seg_valid && seg_ready;

    sgm_frag_slot u_src_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (src_valid),
        .in_ready (src_ready),
        .in_desc  (src_desc),
        .take     (fire),
        .take_len (len),
        .finish   (s_done),
        .held     (s_held),
        .frag     (s_frag)
    );

    sgm_frag_slot u_dst_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (dst_valid),
        .in_ready (dst_ready),
        .in_desc  (dst_desc),
        .take     (fire),
        .take_len (len),
        .finish   (d_done),
        .held     (d_held),
        .frag     (d_frag)
    );

    sgm_seg_split u_split (
        .src_rem  (s_frag.rem),
        .dst_rem  (d_frag.rem),
        .src_eop  (s_frag.flags[FLG_MARK]),
        .dst_skip (d_frag.flags[FLG_MARK]),
        .len      (len),
        .src_done (s_done),
        .dst_done (d_done),
        .last     (last)
    );

    sgm_cpl_track #(.PKT_CNT_W(PKT_CNT_W)) u_cpl (
        .clk            (clk),
        .rst_n          (rst_n),
        .fire           (fire),
        .last           (last),
        .len            (len),
        .src_uid        (s_frag.uid),
        .src_handle     (s_frag.handle),
        .dst_handle     (d_frag.handle),
        .irq            (s_frag.flags[FLG_IRQ]),
        .cpl_valid      (cpl_valid),
        .cpl_user_id    (cpl_user_id),
        .cpl_src_handle (cpl_src_handle),
        .cpl_dst_handle (cpl_dst_handle),
        .cpl_irq        (cpl_irq),
        .cpl_bytes      (cpl_bytes)
    );

    assign seg_src_addr = s_frag.addr;
    assign seg_dst_addr = d_frag.addr;
    assign seg_len      = len;
    assign seg_src_attr = s_frag.flags[FLG_ATTR +: ATTR_W];
    assign seg_dst_attr = d_frag.flags[FLG_ATTR +: ATTR_W];
    assign seg_src_axi  = s_frag.flags[FLG_SIDE];
    assign seg_dst_axi  = d_frag.flags[FLG_SIDE];
    assign seg_last     = last;

    // Reserved flag bits and the destination's tag field carry no function here.
    assign unused_bits = ^{s_frag.flags[3], d_frag.flags[3:2], d_frag.uid};
endmodule

// File: rtl/sgm_checker.sv
// Port-level properties of the merge engine, bound to every instance.
module sgm_checker
    import sgm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              src_valid,
    input logic              src_ready,
    input logic              dst_valid,
    input logic              dst_ready,
    input logic              seg_valid,
    input logic              seg_ready,
    input logic [ADDR_W-1:0] seg_src_addr,
    input logic [ADDR_W-1:0] seg_dst_addr,
    input logic [LEN_W-1:0]  seg_len,
    input logic              seg_last,
    input logic              cpl_valid
);
    AST_SEG_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> (seg_len != '0 && seg_len <= (LEN_W'(1) << CNT_W))); // R3
    AST_SRC_TAKEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid && src_ready) |=> !src_ready); // R4
    AST_DST_TAKEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_valid && dst_ready) |=> !dst_ready); // R4
    AST_SEG_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> (!src_ready && !dst_ready)); // R4
    AST_SEG_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_src_addr) &&
        $stable(seg_dst_addr) && $stable(seg_len) && $stable(seg_last))); // R11
    AST_CPL_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && seg_ready && seg_last) |=> cpl_valid); // R7
    AST_CPL_ONLY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> $past(seg_valid && seg_ready && seg_last)); // R7
endmodule

bind sg_merge_engine sgm_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_valid    (src_valid),
    .src_ready    (src_ready),
    .dst_valid    (dst_valid),
    .dst_ready    (dst_ready),
    .seg_valid    (seg_valid),
    .seg_ready    (seg_ready),
    .seg_src_addr (seg_src_addr),
    .seg_dst_addr (seg_dst_addr),
    .seg_len      (seg_len),
    .seg_last     (seg_last),
    .cpl_valid    (cpl_valid)
);

// File: tb/sg_merge_engine_tb.sv
// Bench: behavioural reference model compared against the engine every clock.
module sg_merge_engine_tb;
    localparam int PCW = 27;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         src_valid = 1'b0, dst_valid = 1'b0, seg_ready = 1'b0;
    logic [127:0] src_desc = '0, dst_desc = '0;
    logic         src_ready, dst_ready, seg_valid, seg_src_axi, seg_dst_axi, seg_last;
    logic [63:0]  seg_src_addr, seg_dst_addr;
    logic [24:0]  seg_len;
    logic [3:0]   seg_src_attr, seg_dst_attr;
    logic         cpl_valid, cpl_irq;
    logic [15:0]  cpl_user_id, cpl_src_handle, cpl_dst_handle;
    logic [PCW-1:0] cpl_bytes;

    always #4 clk = ~clk; // 125 MHz

    sg_merge_engine #(.PKT_CNT_W(PCW)) u_dut (.*);

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [127:0] mk(input logic [63:0] a, input int cnt,
            input logic [7:0] fl, input logic [15:0] h, input logic [15:0] u);
        logic [23:0] c;
        c = cnt[23:0];
        return {u, h, fl, c, a};
    endfunction

    logic [127:0] sq[$];
    logic [127:0] dq[$];
    int n_pkts = 0;
    int n_cpl  = 0;

    // Reference model state
    bit          ms_ld = 0, md_ld = 0;
    logic [63:0] ms_a, md_a;
    longint      ms_r, md_r;
    logic [7:0]  ms_f, md_f;
    logic [15:0] ms_h, ms_u, md_h;
    longint      m_acc = 0;
    bit          mc_v = 0;
    logic [15:0] mc_u, mc_sh, mc_dh;
    bit          mc_i;
    longint      mc_b;
    bit          stalled = 0;

    task automatic push_src(input logic [63:0] a, input int cnt, input logic [7:0] fl,
                            input logic [15:0] h, input logic [15:0] u);
        sq.push_back(mk(a, cnt, fl, h, u));
        if (fl[1]) n_pkts++;
    endtask

    initial begin
        // Directed cases. Source flags: bit0 side, bit1 end of packet, bit2 irq,
        // [7:4] attribute. Destination flags: bit1 skip rest at packet end.
        push_src(64'h1000, 300, 8'h33, 16'h0001, 16'hA001);   // single fragment
        dq.push_back(mk(64'h8000, 300, 8'h51, 16'h0011, 16'h0));
        push_src(64'h2000, 100, 8'h84, 16'h0002, 16'hA002);   // irq on non-EOP: R8
        push_src(64'h3000, 200, 8'h92, 16'h0003, 16'hA003);
        dq.push_back(mk(64'h9000, 150, 8'h60, 16'h0012, 16'h0));
        dq.push_back(mk(64'hA000, 1000, 8'h71, 16'h0013, 16'h0)); // packed
        push_src(64'h4000, 200, 8'h16, 16'h0004, 16'hA004);   // irq on EOP
        push_src(64'h5000, 100, 8'h22, 16'h0005, 16'hA005);
        push_src(64'h6000, 550, 8'h22, 16'h0006, 16'hA006);   // both end together
        dq.push_back(mk(64'hB000, 1000, 8'h82, 16'h0014, 16'h0)); // skip
        push_src(64'h7000, 200, 8'h23, 16'h0007, 16'hA007);
        dq.push_back(mk(64'hC000, 0, 8'h02, 16'h0015, 16'h0));    // 2^24, skip
        push_src(64'h7100, 50, 8'h02, 16'h0008, 16'hA008);
        push_src(64'hD000, 0, 8'hF3, 16'h0009, 16'hA009);     // 2^24 both: R2
        dq.push_back(mk(64'hE000, 0, 8'hE1, 16'h0016, 16'h0));
        // Mixed random packets
        for (int p = 0; p < 20; p++) begin
            int ne;
            ne = $urandom_range(1, 3);
            for (int e = 0; e < ne; e++)
                push_src(64'h10_0000 + 64'(p * 4096 + e * 256), $urandom_range(1, 64),
                         {4'($urandom_range(0, 15)), 1'b0, 1'($urandom_range(0, 1)),
                          (e == ne - 1), 1'($urandom_range(0, 1))},
                         16'(p * 8 + e), 16'hB000 + 16'(p));
        end
        for (int d = 0; d < 100; d++)
            dq.push_back(mk(64'h80_0000 + 64'(d * 4096), $urandom_range(64, 127),
                            {4'($urandom_range(0, 15)), 2'b00, 1'($urandom_range(0, 1)),
                             1'($urandom_range(0, 1))}, 16'h4000 + 16'(d), 16'h0));
    end

    initial begin : run
        int  cyc;
        bit  sv_gate, dv_gate;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(src_ready === 1'b1 && dst_ready === 1'b1, "R12", "ready in reset",
            {src_ready, dst_ready}, 2'b11);
        chk(seg_valid === 1'b0 && cpl_valid === 1'b0, "R12", "valid in reset",
            {seg_valid, cpl_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(src_ready === 1'b1 && dst_ready === 1'b1 && seg_valid === 1'b0 && cpl_valid === 1'b0,
            "R12", "state after reset", {src_ready, dst_ready, seg_valid, cpl_valid}, 4'b1100);
        cyc = 0;
        while (cyc < 20000 && !(sq.size() == 0 && !ms_ld && !mc_v)) begin
            bit          e_sv, fire, s_le, d_le, last;
            longint      len;
            @(negedge clk);
            sv_gate = ($urandom_range(0, 4) != 0);
            dv_gate = ($urandom_range(0, 4) != 0);
            src_valid = (sq.size() > 0) && sv_gate;
            src_desc  = (sq.size() > 0) ? sq[0] : '0;
            dst_valid = (dq.size() > 0) && dv_gate;
            dst_desc  = (dq.size() > 0) ? dq[0] : '0;
            seg_ready = ($urandom_range(0, 3) != 0);
            #1;
            // Expected outputs from model state
            chk(src_ready === !ms_ld, "R4", "src_ready", src_ready, !ms_ld);
            chk(dst_ready === !md_ld, "R4", "dst_ready", dst_ready, !md_ld);
            e_sv = ms_ld && md_ld;
            chk(seg_valid === e_sv, "R4", "seg_valid", seg_valid, e_sv);
            s_le = (ms_r <= md_r);
            d_le = (md_r <= ms_r);
            len  = s_le ? ms_r : md_r;
            last = s_le && ms_f[1];
            if (e_sv) begin
                chk(seg_len === 25'(len), stalled ? "R11" : "R2/R3", "seg_len", seg_len, len);
                chk(seg_src_addr === ms_a, stalled ? "R11" : "R1/R3", "seg_src_addr", seg_src_addr, ms_a);
                chk(seg_dst_addr === md_a, stalled ? "R11" : "R3/R6", "seg_dst_addr", seg_dst_addr, md_a);
                chk(seg_last === last, "R5", "seg_last", seg_last, last);
                chk(seg_src_attr === ms_f[7:4] && seg_dst_attr === md_f[7:4], "R10", "attr",
                    {seg_src_attr, seg_dst_attr}, {ms_f[7:4], md_f[7:4]});
                chk(seg_src_axi === ms_f[0] && seg_dst_axi === md_f[0], "R10", "side",
                    {seg_src_axi, seg_dst_axi}, {ms_f[0], md_f[0]});
            end
            chk(cpl_valid === mc_v, "R7", "cpl_valid", cpl_valid, mc_v);
            if (mc_v) begin
                n_cpl++;
                chk(cpl_user_id === mc_u && cpl_src_handle === mc_sh, "R1/R7", "src tags",
                    {cpl_user_id, cpl_src_handle}, {mc_u, mc_sh});
                chk(cpl_dst_handle === mc_dh, "R7", "dst handle", cpl_dst_handle, mc_dh);
                chk(cpl_irq === mc_i, "R8", "cpl_irq", cpl_irq, mc_i);
                chk(cpl_bytes === PCW'(mc_b), "R9", "cpl_bytes", cpl_bytes, PCW'(mc_b));
            end
            // Model step for the coming clock edge
            fire    = e_sv && seg_ready;
            stalled = e_sv && !seg_ready;
            mc_v    = fire && last;
            if (fire && last) begin
                mc_u = ms_u; mc_sh = ms_h; mc_dh = md_h; mc_i = ms_f[2];
                mc_b = m_acc + len;
                m_acc = 0;
            end else if (fire) begin
                m_acc = m_acc + len;
            end
            if (src_valid && !ms_ld) begin
                logic [127:0] d;
                d = sq.pop_front();
                ms_ld = 1; ms_a = d[63:0]; ms_r = (d[87:64] == 0) ? (64'd1 << 24) : longint'(d[87:64]);
                ms_f = d[95:88]; ms_h = d[111:96]; ms_u = d[127:112];
            end else if (fire) begin
                ms_a = ms_a + 64'(len); ms_r = ms_r - len;
                if (s_le) ms_ld = 0;
            end
            if (dst_valid && !md_ld) begin
                logic [127:0] d;
                d = dq.pop_front();
                md_ld = 1; md_a = d[63:0]; md_r = (d[87:64] == 0) ? (64'd1 << 24) : longint'(d[87:64]);
                md_f = d[95:88]; md_h = d[111:96];
            end else if (fire) begin
                md_a = md_a + 64'(len); md_r = md_r - len;
                if (d_le || (last && md_f[1])) md_ld = 0;
            end
            cyc++;
        end
        if (cyc >= 20000) begin
            errors++;
            $display("FAIL watchdog R4 actual=%0d expected=<%0d", cyc, 20000);
        end
        chk(n_cpl == n_pkts, "R7", "completion count", n_cpl, n_pkts);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule